// File: doc/BRIEF.md
# Bus Read Cycle Sequencer

This block runs the processor side of a single memory read over a plain parallel bus. The bus has an address output, a data input and an active-low read strobe. Memory on this bus answers more slowly than the core, so one read takes several machine cycles. The core raises a request with an address. The sequencer then puts that address on the bus and leaves it there. One cycle later it pulls the strobe low and holds it low through a parameterised number of wait cycles. After that it lets the strobe go high again. The memory has valid data on the bus while the strobe is high in that cycle, and the sequencer takes the data in at the end of it. In the next cycle it returns the data together with a one-cycle completion pulse.

Only one transaction is handled at a time. While the sequencer is busy, further requests are dropped and not queued. The core must present the request again once the busy output has fallen.

Top module: `bus_read_seq`

## Requirements
- R1: After reset, `bus_rd_n` is 1 and `busy` and `done` are 0.
- R2: When `req` is sampled high while idle, the next cycle shows `req_addr` on `bus_addr`, `busy` at 1 and `bus_rd_n` still at 1. This is the address phase.
- R3: Starting in the second cycle after acceptance, `bus_rd_n` is 0 for exactly 1 + WAIT_STATES consecutive cycles.
- R4: After the low run, `bus_rd_n` is 1 for one cycle while still busy. The value on `bus_data` at the end of that cycle is the one returned on `rd_data`. Values present while the strobe was low are not used.
- R5: `done` is 1 for exactly one cycle, the cycle after the strobe release. `rd_data` is valid in that cycle and keeps its value until the next `done`.
- R6: `bus_addr` keeps the accepted address without change from the address phase through the `done` cycle.
- R7: `busy` is 1 for exactly 4 + WAIT_STATES consecutive cycles, from the cycle after acceptance through the `done` cycle.
- R8: A request raised while `busy` is 1, the `done` cycle included, is ignored. It starts no transaction and leaves `bus_addr` unchanged. A request in the first idle cycle after `done` is accepted.
- R9: WAIT_STATES is at least 1. An internal counter sets the length of the wait stretch, and the bench uses WAIT_STATES = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Read request from the core |
| req_addr | input | ADDR_W | Address of the requested read |
| busy | output | 1 | Transaction in progress, through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address bus to memory |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_data | input | DATA_W | Data bus from memory |

## Verification
Two events can fall in the same cycle: the completion pulse and a new request from the core. A request in the `done` cycle must be dropped, and a request one cycle later must start a new transaction. The bench provokes the first case by holding `req` high, with a changing address, through a whole transaction and its `done` cycle. It then drops `req` and checks that `busy` stays low and that `bus_addr` did not move. It provokes the second case by raising `req` exactly one cycle after `done` and checking that the next address phase appears on time. A bench memory model drives the inverse of the correct data whenever the strobe is low or the transaction is idle. A capture taken one cycle too early or too late therefore shows up in the returned data.

// File: rtl/bus_read_seq_pkg.sv
// Package: shared state encoding for the bus read sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package bus_read_seq_pkg;

    // Transaction phases, in the order a read walks through them.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR    = 3'd1,
        PH_STROBE  = 3'd2,
        PH_WAIT    = 3'd3,
        PH_RELEASE = 3'd4
    } rd_phase_e;

endpackage

// File: rtl/bus_read_seq_wait_ctr.sv
// Module: wait-state counter. It is loaded when the sequencer enters its
// wait stretch and signals on the last wait cycle.
// Assumes: WAIT_STATES >= 1. With a single wait state no counter is built.
module bus_read_seq_wait_ctr #(
    parameter int WAIT_STATES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);

    localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;

    generate
        if (WAIT_STATES <= 1) begin : g_single
            // A single wait cycle is always the last one.
            assign last = 1'b1;
        end else begin : g_counted
            logic [CNT_W-1:0] remain_q;

            // Load the cycles left after the first one, then count them down while waiting.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    remain_q <= '0;
                end else if (load) begin
                    remain_q <= CNT_W'(WAIT_STATES - 1);
                end else if (run && remain_q != '0) begin
                    remain_q <= remain_q - 1'b1;
                end
            end

            assign last = (remain_q == '0);

            AST_CNT_NO_RELOAD_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !last) |=> !last || (remain_q < $past(remain_q))); // R9
        end
    endgenerate

endmodule

// File: rtl/bus_read_seq_fsm.sv
// Module: phase controller for a single bus read. It walks through address,
// strobe, wait and release phases and drives the registered read strobe.
// Assumes: the capture unit raises done_pulse in the cycle after release.
// Requests are only taken when idle and not in that done cycle.
module bus_read_seq_fsm
    import bus_read_seq_pkg::*;
#(
    parameter int WAIT_STATES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic done_pulse,
    output logic accept,
    output logic capture,
    output logic active,
    output logic strobe_n
);

    rd_phase_e phase_q, phase_d;
    logic      wait_last;
    logic      wait_load;
    logic      wait_run;
    logic      strobe_n_q;

    // Pick the next phase from the current one.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (req && !done_pulse) phase_d = PH_ADDR;
            PH_ADDR:    phase_d = PH_STROBE;
            PH_STROBE:  phase_d = PH_WAIT;
            PH_WAIT:    if (wait_last) phase_d = PH_RELEASE;
            PH_RELEASE: phase_d = PH_IDLE;
            default:    phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Registered strobe: low exactly while the next phase is strobe or wait.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_n_q <= 1'b1;
        else        strobe_n_q <= !(phase_d == PH_STROBE || phase_d == PH_WAIT);
    end

    assign wait_load = (phase_q == PH_STROBE);
    assign wait_run  = (phase_q == PH_WAIT);

    bus_read_seq_wait_ctr #(
        .WAIT_STATES(WAIT_STATES)
    ) i_wait_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wait_load),
        .run  (wait_run),
        .last (wait_last)
    );

    assign accept   = (phase_q == PH_IDLE) && req && !done_pulse;
    assign capture  = (phase_q == PH_RELEASE);
    assign active   = (phase_q != PH_IDLE);
    assign strobe_n = strobe_n_q;

    AST_ADDR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ADDR) |-> strobe_n); // R2
    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> strobe_n); // R4
    AST_RELEASE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> done_pulse); // R5
    AST_IDLE_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> strobe_n); // R1

endmodule

// File: rtl/bus_read_seq_capture.sv
// Module: address latch and read-data holding register with done pulse.
// Assumes: accept and capture come from the phase controller and never
// fall in the same cycle.
module bus_read_seq_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_pulse
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q;

    // Hold the accepted address on the bus until the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    // Take the data bus at the end of the release cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= bus_data;
    end

    // One-cycle completion pulse that follows the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= capture;
    end

    assign bus_addr   = addr_q;
    assign rd_data    = data_q;
    assign done_pulse = done_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R5
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> $stable(data_q)); // R5
    AST_ADDR_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) |-> $stable(addr_q)); // R6

endmodule

// File: rtl/bus_read_seq.sv
// Module: top of the bus read sequencer. It joins the phase controller and
// the capture unit and widens busy so that it covers the done cycle.
// Assumes: memory drives valid data while the strobe is high in the release
// cycle, and WAIT_STATES >= 1.
module bus_read_seq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int WAIT_STATES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd_n,
    input  logic [DATA_W-1:0] bus_data
);

    localparam int LOW_CYCLES = WAIT_STATES + 1;
    localparam int RUN_W      = $clog2(LOW_CYCLES + 2);

    logic accept;
    logic capture;
    logic active;
    logic done_pulse;

    bus_read_seq_fsm #(
        .WAIT_STATES(WAIT_STATES)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .done_pulse(done_pulse),
        .accept    (accept),
        .capture   (capture),
        .active    (active),
        .strobe_n  (bus_rd_n)
    );

    bus_read_seq_capture #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .capture   (capture),
        .bus_data  (bus_data),
        .bus_addr  (bus_addr),
        .rd_data   (rd_data),
        .done_pulse(done_pulse)
    );

    assign busy = active || done_pulse;
    assign done = done_pulse;

    // Checker counter: length of the current strobe-low run.
    logic [RUN_W-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         low_run_q <= '0;
        else if (!bus_rd_n) low_run_q <= low_run_q + 1'b1;
        else                low_run_q <= '0;
    end

    AST_LOW_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= RUN_W'(LOW_CYCLES)); // R3
    AST_LOW_RUN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_n && low_run_q != '0) |-> (low_run_q == RUN_W'(LOW_CYCLES))); // R3
    AST_ADDR_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr)); // R6
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept); // R8

endmodule

// File: tb/test_bus_read_seq.sv
// Bench: sweeps addresses through single reads, back-to-back reads and
// requests raised while busy, against a memory model whose data is valid only
// while the strobe is high after it has been low.
module test_bus_read_seq;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, done, bus_rd_n;
    logic [DW-1:0] rd_data, bus_data;
    logic [AW-1:0] bus_addr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic mem_armed = 1'b0;

    always #10 clk = ~clk;

    bus_read_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_STATES(WS)) i_bus_read_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .busy(busy), .done(done), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_data(bus_data)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return DW'(a * 16'd37 + 16'd5) ^ 16'hA5C3;
    endfunction

    // Memory model: correct data only after the strobe was low and has returned high.
    always_ff @(posedge clk) begin
        if (!rst_n || done) mem_armed <= 1'b0;
        else if (!bus_rd_n) mem_armed <= 1'b1;
    end
    assign bus_data = (mem_armed && bus_rd_n) ? mem_val(bus_addr) : ~mem_val(bus_addr);

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", "run exceeded cycle limit", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Run one read. If hold is set, req stays high with a changing address
    // until after the done cycle (R8).
    task automatic do_read(input logic [AW-1:0] a, input bit hold);
        int busy_n = 0;
        int low_n  = 0;
        int done_n = 0;
        bit addr_ok = 1'b1;
        bit early_cap = 1'b0;
        @(negedge clk);
        req = 1'b1;
        req_addr = a;
        @(negedge clk);
        // R2 address phase
        check(busy == 1'b1 && bus_rd_n == 1'b1 && bus_addr == a, "R2",
              "address phase", {busy, bus_rd_n, bus_addr}, {2'b11, a});
        if (!hold) req = 1'b0;
        for (int k = 0; k < 20 && busy; k++) begin
            busy_n++;
            if (!bus_rd_n) low_n++;
            if (done) begin
                done_n++;
                // R4 captured value equals the memory's value at release
                check(rd_data == mem_val(a), "R4", "captured data", rd_data, mem_val(a));
            end else if (k > 0 && bus_rd_n && low_n == WS + 1) begin
                early_cap = 1'b1; // release cycle
            end
            if (bus_addr != a) addr_ok = 1'b0;
            if (hold) req_addr = a ^ AW'(k + 1);
            @(negedge clk);
        end
        req = 1'b0;
        check(busy_n == 4 + WS, "R7", "busy length", busy_n, 4 + WS);
        check(low_n == 1 + WS, "R3", "strobe low length", low_n, 1 + WS);
        check(done_n == 1 && early_cap, "R5", "single done after release", done_n, 1);
        check(addr_ok, "R6", "address stable while busy", addr_ok, 1);
        if (hold) begin
            // R8: the request held through done started nothing
            @(negedge clk);
            check(busy == 1'b0 && bus_addr == a, "R8", "request in done cycle ignored",
                  {busy, bus_addr}, {1'b0, a});
        end
        // R5 data held after done
        check(rd_data == mem_val(a) && !done, "R5", "data held when idle", rd_data, mem_val(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_rd_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1", "reset state",
              {bus_rd_n, busy, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_rd_n == 1'b1 && busy == 1'b0, "R1", "idle after reset", {bus_rd_n, busy}, 2'b10);

        // Sweep: walking ones, plus the all-zero and all-one corners.
        do_read('0, 1'b0);
        do_read('1, 1'b0);
        for (int b = 0; b < AW; b++) do_read(AW'(1) << b, 1'b0);
        for (int b = 0; b < 4; b++) do_read(AW'(16'h1234 * (b + 1)), 1'b1);

        // R8 back-to-back: a request in the first idle cycle after done is accepted.
        begin
            logic [AW-1:0] a2 = 16'hBEEF;
            do_read(16'h0F0F, 1'b0);
            // do_read returned at the idle cycle after done; request now.
            req = 1'b1;
            req_addr = a2;
            @(negedge clk);
            check(busy == 1'b1 && bus_addr == a2, "R8", "accept right after done",
                  {busy, bus_addr}, {1'b1, a2});
            req = 1'b0;
            for (int k = 0; k < 20 && busy; k++) @(negedge clk);
            check(rd_data == mem_val(a2), "R9", "read with counted wait states", rd_data, mem_val(a2));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule